// File: doc/BRIEF.md
# Two-Core Interrupt Acknowledge Distributor

This block routes interrupt lines to two CPU interfaces and tracks the state of every interrupt: inactive, pending, active, or active with a new request waiting. There are two kinds of interrupt. A per-core interrupt exists once for each core, and each copy is raised, acknowledged and retired by its own core alone. A shared interrupt can be delivered to any core whose enable bit is set in that interrupt's target mask, but only one core may take it.

A core reads its acknowledge port by pulsing `ack_rd`. The read returns the lowest-numbered interrupt that the core could take, and that interrupt becomes active. If there is nothing the core can take, the read returns the spurious code 1023. The core later writes the same ID to its end-of-interrupt port, which returns the interrupt to inactive. Once a core has acknowledged a shared interrupt, every other core stops seeing it at once. This holds even while a level-sensitive line stays high, and it lasts until the owner retires the interrupt.

Top module: `irqd_top`

## Requirements
- R1: After reset, `irq_out` is all zero and every `ack_id` reads 1023.
- R2: IDs 0 to NPRIV-1 are per-core interrupts, driven for core c by `priv_line[c][i]`. Such an interrupt is offered only to its own core. A read by another core does not return it, and it is retired by an end-of-interrupt write from its own core.
- R3: Shared line k carries ID NPRIV+k. It is offered only to the cores whose bit is set in `tgt_en[k]`, and a read by a core whose bit is clear returns 1023.
- R4: A read returns the lowest ID among the interrupts that are pending, not active and targeted at the reading core. `ack_id[c]` is updated at the clock edge that samples `ack_rd[c]` and holds its value until the next read. `irq_out[c]` is high exactly when such an interrupt exists.
- R5: A read by a core with no interrupt to take returns 1023 and changes no interrupt state.
- R6: A shared interrupt that has been acknowledged is offered to no core until it is retired. This holds even while its level-sensitive line stays high, so another core's read skips it.
- R7: When two cores read in the same cycle and both would select the same shared ID, the lower-numbered core receives the ID and the other core receives 1023.
- R8: An end-of-interrupt write retires a shared interrupt only if it comes from the core that acknowledged it and names its ID. A write from another core, or a write with a different ID, has no effect.
- R9: When `cfg_edge[id]` is 0, the interrupt is level-sensitive. It is pending while its line is high and the interrupt is inactive, and it is withdrawn if the line drops before it is acknowledged. If the line is still high when the interrupt is retired, the interrupt is offered again one cycle after the retiring edge.
- R10: When `cfg_edge[id]` is 1, the interrupt is edge-triggered. It becomes pending only on a rising edge of its line. A rising edge that arrives while the interrupt is active is held, and the interrupt is offered again as soon as it is retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_line | input | NCORE x NPRIV | Per-core interrupt lines |
| shr_line | input | NSHR | Shared interrupt lines |
| cfg_edge | input | NPRIV+NSHR | Per-ID trigger select: 1 edge, 0 level |
| tgt_en | input | NSHR x NCORE | Per-shared-interrupt core enable mask |
| ack_rd | input | NCORE | Acknowledge read strobe, one per core |
| ack_id | output | NCORE x 10 | Acknowledged ID, or 1023 |
| eoi_wr | input | NCORE | End-of-interrupt write strobe, one per core |
| eoi_id | input | NCORE x 10 | ID written at end of interrupt |
| irq_out | output | NCORE | Interrupt request to each core |

## Verification
A change on a line reaches `irq_out` after one clock edge. An acknowledge read updates `ack_id` and withdraws the interrupt from `irq_out` at the edge that samples the strobe. A retire write clears the active state at its own edge. A level-sensitive line that is still high raises the request one edge after that. The bench drives inputs on the falling edge and samples on the next falling edge, so every expected value is compared after exactly the number of edges stated above. The random phase updates a bench model on every rising edge and compares the outputs with it on every falling edge.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int IDW = 10;
  typedef logic [IDW-1:0] irq_id_t;
  localparam irq_id_t SPUR_ID = irq_id_t'(1023);
endpackage

// File: rtl/irqd_cell.sv
// One interrupt state holder: pending and active bits plus line history.
module irqd_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic edge_i,
  input  logic grant_i,
  input  logic eoi_i,
  output logic pend_o,
  output logic act_o
);
  logic line_q, pend_q, act_q;
  logic pend_d, act_d, rise;

  always_comb begin
    rise = line_i & ~line_q;
    if (edge_i) pend_d = rise | (pend_q & ~grant_i);
    else        pend_d = line_i & ~act_q & ~grant_i;
    act_d = grant_i | (act_q & ~eoi_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      line_q <= line_i;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/irqd_pick.sv
// Lowest-index selector over a request vector.
module irqd_pick import irqd_pkg::*; #(
  parameter int N = 12
) (
  input  logic [N-1:0] req_i,
  output logic         vld_o,
  output irq_id_t      idx_o
);
  always_comb begin
    vld_o = |req_i;
    idx_o = SPUR_ID;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = irq_id_t'(i);
    end
  end
endmodule

// File: rtl/irqd_top.sv
module irqd_top import irqd_pkg::*; #(
  parameter int NCORE = 2,
  parameter int NPRIV = 4,
  parameter int NSHR  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NCORE-1:0][NPRIV-1:0]      priv_line,
  input  logic [NSHR-1:0]                  shr_line,
  input  logic [NPRIV+NSHR-1:0]            cfg_edge,
  input  logic [NSHR-1:0][NCORE-1:0]       tgt_en,
  input  logic [NCORE-1:0]                 ack_rd,
  output logic [NCORE-1:0][IDW-1:0]        ack_id,
  input  logic [NCORE-1:0]                 eoi_wr,
  input  logic [NCORE-1:0][IDW-1:0]        eoi_id,
  output logic [NCORE-1:0]                 irq_out
);
  localparam int NIRQ = NPRIV + NSHR;
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1;

  logic [NCORE-1:0][NPRIV-1:0] priv_pend, priv_act, priv_grant, priv_eoi;
  logic [NSHR-1:0]             shr_pend, shr_act, shr_grant, shr_eoi;
  logic [NSHR-1:0][CW-1:0]     shr_own_q, shr_own_d;
  logic [NCORE-1:0][NIRQ-1:0]  cand;
  logic [NCORE-1:0]            sel_vld, ack_ok;
  irq_id_t [NCORE-1:0]         sel_id, ack_id_q, ack_id_d;

  // State holders: one per core per private ID, one per shared ID.
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar i = 0; i < NPRIV; i++) begin : g_priv
      irqd_cell u_pc (
        .clk(clk), .rst_n(rst_n), .line_i(priv_line[c][i]), .edge_i(cfg_edge[i]),
        .grant_i(priv_grant[c][i]), .eoi_i(priv_eoi[c][i]),
        .pend_o(priv_pend[c][i]), .act_o(priv_act[c][i]));
    end

    always_comb begin
      cand[c][NPRIV-1:0] = priv_pend[c] & ~priv_act[c];
      for (int k = 0; k < NSHR; k++)
        cand[c][NPRIV+k] = shr_pend[k] & ~shr_act[k] & tgt_en[k][c];
    end

    irqd_pick #(.N(NIRQ)) u_pick (
      .req_i(cand[c]), .vld_o(sel_vld[c]), .idx_o(sel_id[c]));

    assign irq_out[c] = sel_vld[c];
  end

  for (genvar k = 0; k < NSHR; k++) begin : g_shr
    irqd_cell u_sc (
      .clk(clk), .rst_n(rst_n), .line_i(shr_line[k]), .edge_i(cfg_edge[NPRIV+k]),
      .grant_i(shr_grant[k]), .eoi_i(shr_eoi[k]),
      .pend_o(shr_pend[k]), .act_o(shr_act[k]));
  end

  // Grant: cores are served in index order, so a lower core claims a
  // shared ID before a higher core can.
  always_comb begin
    priv_grant = '0;
    shr_grant  = '0;
    shr_own_d  = shr_own_q;
    ack_ok     = '0;
    for (int c = 0; c < NCORE; c++) begin
      if (ack_rd[c] && sel_vld[c]) begin
        for (int i = 0; i < NPRIV; i++) begin
          if (sel_id[c] == irq_id_t'(i)) begin
            priv_grant[c][i] = 1'b1;
            ack_ok[c]        = 1'b1;
          end
        end
        for (int k = 0; k < NSHR; k++) begin
          if (sel_id[c] == irq_id_t'(NPRIV + k) && !shr_grant[k]) begin
            shr_grant[k] = 1'b1;
            shr_own_d[k] = CW'(c);
            ack_ok[c]    = 1'b1;
          end
        end
      end
      ack_id_d[c] = ack_ok[c] ? sel_id[c] : SPUR_ID;
    end
  end

  // Retire: private copies by their own core, shared ones by the owner only.
  always_comb begin
    priv_eoi = '0;
    shr_eoi  = '0;
    for (int c = 0; c < NCORE; c++) begin
      for (int i = 0; i < NPRIV; i++)
        priv_eoi[c][i] = eoi_wr[c] && (eoi_id[c] == irq_id_t'(i));
      for (int k = 0; k < NSHR; k++)
        if (eoi_wr[c] && eoi_id[c] == irq_id_t'(NPRIV + k) && shr_own_q[k] == CW'(c))
          shr_eoi[k] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_own_q <= '0;
    end else if (|shr_grant) begin
      shr_own_q <= shr_own_d;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_ack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ack_id_q[c] <= SPUR_ID;
      end else if (ack_rd[c]) begin
        ack_id_q[c] <= ack_id_d[c];
      end
    end
  end

  assign ack_id = ack_id_q;
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk import irqd_pkg::*; #(
  parameter int NCORE = 2,
  parameter int NPRIV = 4,
  parameter int NSHR  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCORE-1:0]          ack_rd,
  input logic [NCORE-1:0][IDW-1:0] ack_id,
  input logic [NCORE-1:0]          irq_out,
  input logic [NPRIV+NSHR-1:0]     cfg_edge,
  input logic [NSHR-1:0]           shr_pend,
  input logic [NSHR-1:0]           shr_act
);
  for (genvar c = 0; c < NCORE; c++) begin : g_c
    a_r5_idle_read_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd[c] && !irq_out[c]) |=> ack_id[c] == SPUR_ID)
      else $error("R5: read with no request did not return 1023");
    a_r4_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd[c] |=> (ack_id[c] < IDW'(NPRIV + NSHR)) || (ack_id[c] == SPUR_ID))
      else $error("R4: acknowledged ID out of range");
  end

  a_r7_low_core_served: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd[0] && irq_out[0]) |=> ack_id[0] != SPUR_ID)
    else $error("R7: core 0 lost a read it should win");

  if (NCORE > 1) begin : g_pair
    a_r6_single_holder: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd[0] && ack_rd[1]) |=>
        !(ack_id[0] == ack_id[1] && ack_id[0] >= IDW'(NPRIV) && ack_id[0] != SPUR_ID))
      else $error("R6: one shared ID given to two cores");
  end

  for (genvar k = 0; k < NSHR; k++) begin : g_k
    a_r6_level_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
      (shr_act[k] && !cfg_edge[NPRIV+k]) |-> !shr_pend[k])
      else $error("R6: active level shared interrupt still pending");
  end
endmodule

bind irqd_top irqd_chk #(.NCORE(NCORE), .NPRIV(NPRIV), .NSHR(NSHR)) u_chk (.*);

// File: tb/irqd_top_tb.sv
module irqd_top_tb;
  import irqd_pkg::*;
  localparam int NC = 2, NP = 4, NS = 8, NI = NP + NS;
  localparam int SP = 1023;
  localparam int LIMIT = 60000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                      rst_n;
  logic [NC-1:0][NP-1:0]     priv_line;
  logic [NS-1:0]             shr_line;
  logic [NI-1:0]             cfg_edge;
  logic [NS-1:0][NC-1:0]     tgt_en;
  logic [NC-1:0]             ack_rd, eoi_wr, irq_out;
  logic [NC-1:0][IDW-1:0]    ack_id, eoi_id;

  irqd_top #(.NCORE(NC), .NPRIV(NP), .NSHR(NS)) u_dut (.*);

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Reference model, updated on every rising edge.
  bit mpp[NC][NP], mpa[NC][NP], mplq[NC][NP];
  bit msp[NS], msa[NS], mslq[NS];
  int mown[NS];
  int mack[NC];

  function automatic int mpick(int c);
    for (int i = 0; i < NP; i++) if (mpp[c][i] && !mpa[c][i]) return i;
    for (int k = 0; k < NS; k++) if (msp[k] && !msa[k] && tgt_en[k][c]) return NP + k;
    return -1;
  endfunction

  function automatic bit [1:0] cell_next(bit line, bit lq, bit edg, bit p, bit a, bit g, bit e);
    bit pn, an;
    pn = edg ? ((line & ~lq) | (p & ~g)) : (line & ~a & ~g);
    an = g | (a & ~e);
    return {pn, an};
  endfunction

  always @(posedge clk) begin
    int sel[NC];
    bit taken[NS];
    bit pg[NC][NP];
    int win[NS];
    bit e;
    bit [1:0] nx;
    if (!rst_n) begin
      foreach (mpp[c, i]) begin mpp[c][i] = 0; mpa[c][i] = 0; mplq[c][i] = 0; end
      foreach (msp[k]) begin msp[k] = 0; msa[k] = 0; mslq[k] = 0; mown[k] = 0; end
      foreach (mack[c]) mack[c] = SP;
    end else begin
      foreach (taken[k]) begin taken[k] = 0; win[k] = -1; end
      foreach (pg[c, i]) pg[c][i] = 0;
      for (int c = 0; c < NC; c++) sel[c] = mpick(c);
      for (int c = 0; c < NC; c++) begin
        if (ack_rd[c]) begin
          if (sel[c] < 0) mack[c] = SP;
          else if (sel[c] < NP) begin pg[c][sel[c]] = 1; mack[c] = sel[c]; end
          else if (taken[sel[c]-NP]) mack[c] = SP;
          else begin taken[sel[c]-NP] = 1; win[sel[c]-NP] = c; mack[c] = sel[c]; end
        end
      end
      for (int c = 0; c < NC; c++) begin
        for (int i = 0; i < NP; i++) begin
          e = eoi_wr[c] && (int'(eoi_id[c]) == i);
          nx = cell_next(priv_line[c][i], mplq[c][i], cfg_edge[i], mpp[c][i], mpa[c][i], pg[c][i], e);
          {mpp[c][i], mpa[c][i]} = nx;
          mplq[c][i] = priv_line[c][i];
        end
      end
      for (int k = 0; k < NS; k++) begin
        e = 0;
        for (int c = 0; c < NC; c++)
          if (eoi_wr[c] && int'(eoi_id[c]) == NP + k && mown[k] == c) e = 1;
        nx = cell_next(shr_line[k], mslq[k], cfg_edge[NP+k], msp[k], msa[k], taken[k], e);
        {msp[k], msa[k]} = nx;
        mslq[k] = shr_line[k];
        if (taken[k]) mown[k] = win[k];
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(logic [NC-1:0] m);
    ack_rd = m; tick(); ack_rd = '0;
  endtask

  task automatic eoi(logic [NC-1:0] m, int id0, int id1);
    eoi_wr = m; eoi_id[0] = IDW'(id0); eoi_id[1] = IDW'(id1);
    tick(); eoi_wr = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; priv_line = '0; shr_line = '0; cfg_edge = '0;
    tgt_en = '1; ack_rd = '0; eoi_wr = '0; eoi_id = '0;
    tick(3); rst_n = 1; tick();

    // R1
    chk("R1 irq_out", int'(irq_out), 0);
    chk("R1 ack_id0", int'(ack_id[0]), SP);
    chk("R1 ack_id1", int'(ack_id[1]), SP);

    // R5: empty read
    ack(2'b01);
    chk("R5 empty read", int'(ack_id[0]), SP);
    chk("R5 irq after empty read", int'(irq_out), 0);

    // Shared level ID 5
    shr_line[1] = 1; tick();
    chk("R3 shared to both", int'(irq_out), 3);
    ack(2'b11);
    chk("R7 core0 wins", int'(ack_id[0]), 5);
    chk("R7 core1 spurious", int'(ack_id[1]), SP);
    chk("R6 withdrawn", int'(irq_out), 0);
    tick(3);
    chk("R6 line still high", int'(irq_out), 0);
    ack(2'b10);
    chk("R6 other core read", int'(ack_id[1]), SP);
    eoi(2'b10, 0, 5); tick();
    chk("R8 non-owner retire ignored", int'(irq_out), 0);
    eoi(2'b01, 6, 0); tick();
    chk("R8 wrong id ignored", int'(irq_out), 0);
    eoi(2'b01, 5, 0);
    chk("R9 not yet pending", int'(irq_out), 0);
    tick();
    chk("R9 repend after retire", int'(irq_out), 3);
    shr_line[1] = 0; tick();
    chk("R9 level drop withdraws", int'(irq_out), 0);

    // Private ID 2 on core 1
    priv_line[1][2] = 1; tick();
    chk("R2 private to own core", int'(irq_out), 2);
    ack(2'b11);
    chk("R2 own core gets id", int'(ack_id[1]), 2);
    chk("R2 other core spurious", int'(ack_id[0]), SP);
    priv_line[1][2] = 0; eoi(2'b10, 0, 2); tick();
    chk("R2 retired", int'(irq_out), 0);

    // Target mask: ID 7 to core 0 only
    tgt_en[3] = 2'b01; shr_line[3] = 1; tick();
    chk("R3 masked target", int'(irq_out), 1);
    ack(2'b10);
    chk("R3 untargeted read", int'(ack_id[1]), SP);
    ack(2'b01);
    chk("R3 targeted read", int'(ack_id[0]), 7);
    shr_line[3] = 0; eoi(2'b01, 7, 0); tick(); tgt_en[3] = 2'b11;

    // Lowest ID first
    shr_line[6] = 1; shr_line[2] = 1; priv_line[0][3] = 1; tick();
    ack(2'b01);
    chk("R4 private lowest", int'(ack_id[0]), 3);
    priv_line[0][3] = 0; eoi(2'b01, 3, 0); tick();
    ack(2'b01);
    chk("R4 lowest shared", int'(ack_id[0]), 6);
    ack(2'b10);
    chk("R6 active id skipped", int'(ack_id[1]), 10);
    shr_line[6] = 0; shr_line[2] = 0; eoi(2'b11, 6, 10); tick();
    chk("R4 all clear", int'(irq_out), 0);

    // Edge-triggered ID 8
    cfg_edge[8] = 1; shr_line[4] = 1; tick();
    chk("R10 rise pends", int'(irq_out), 3);
    ack(2'b10);
    chk("R10 ack edge", int'(ack_id[1]), 8);
    eoi(2'b10, 0, 8); tick(2);
    chk("R10 high line no repend", int'(irq_out), 0);
    shr_line[4] = 0; tick(); shr_line[4] = 1; tick();
    chk("R10 new rise", int'(irq_out), 3);
    ack(2'b01);
    chk("R10 ack again", int'(ack_id[0]), 8);
    shr_line[4] = 0; tick(); shr_line[4] = 1; tick();
    chk("R10 held while active", int'(irq_out), 0);
    eoi(2'b01, 8, 0);
    chk("R10 active-and-pending offered", int'(irq_out), 3);
    ack(2'b01);
    chk("R10 third ack", int'(ack_id[0]), 8);
    shr_line[4] = 0; eoi(2'b01, 8, 0); tick();
    chk("R10 clear", int'(irq_out), 0);
    cfg_edge[8] = 0;

    // Random phase against the model
    tick();
    cfg_edge = NI'($urandom);
    for (int k = 0; k < NS; k++) begin
      tgt_en[k] = NC'($urandom);
      if (tgt_en[k] == '0) tgt_en[k] = 2'b01;
    end
    for (int n = 0; n < 3000; n++) begin
      tick();
      chk("R4 irq_out vs model", int'(irq_out),
          int'({mpick(1) >= 0, mpick(0) >= 0}));
      chk("R6 ack_id0 vs model", int'(ack_id[0]), mack[0]);
      chk("R7 ack_id1 vs model", int'(ack_id[1]), mack[1]);
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < NP; i++)
          if ($urandom_range(7) == 0) priv_line[c][i] = ~priv_line[c][i];
      for (int k = 0; k < NS; k++)
        if ($urandom_range(7) == 0) shr_line[k] = ~shr_line[k];
      for (int c = 0; c < NC; c++) begin
        ack_rd[c] = ($urandom_range(3) == 0);
        eoi_wr[c] = ($urandom_range(2) == 0);
        eoi_id[c] = ($urandom_range(3) != 0) ? IDW'(mack[c]) : IDW'($urandom_range(NI - 1));
      end
    end
    ack_rd = '0; eoi_wr = '0;
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule